// File: doc/BRIEF.md
# Asynchronous Memory Write Strobe Sequencer

This block turns single access requests from an internal valid/ready port into chip-select, address, data-enable and active-low strobe waveforms for banks of asynchronous external memory or peripherals. Each write holds its bank select and address for one setup clock before the write strobe falls. The strobe stays low for a programmable number of wait clocks and can be stretched further by a slow device through an acknowledge input. After the strobe rises, address and data stay on the bus for a programmable number of hold clocks.

Wait, hold and timeout settings are sampled together with each request. A read request only starts the read strobe; the read path exists so that the write-to-read turnaround can be enforced and the data bus released in time. When a bank is not in asynchronous mode, the programmed wait, hold and acknowledge settings are ignored and a fixed two-clock strobe is used.

Top module: `amw_seq`

## Requirements
- R1: After reset, every chip select (active low) is high, write and read strobes are high, the data enable is low, the error flag is low and the request port is ready.
- R2: For every access exactly one chip select is low, namely bit `req_bank` of `mem_cs_n`. It goes low together with the captured address one clock before the strobe falls, and the address stays constant while that chip select is low.
- R3: In asynchronous mode with acknowledge high, the write strobe stays low for max(W, 2) clocks, where W is `cfg_wait`.
- R4: The data enable is low in the first write-strobe clock and high from the second strobe clock through the last hold clock. It is low in the first clock after chip select is released, and the driven data equals the requested data.
- R5: After a write strobe rises, chip select, address and data stay driven for exactly H clocks, where H is `cfg_hold`. A read has no hold.
- R6: When writes are requested back to back, the next write strobe falls exactly H+2 clocks after the previous write strobe rose, which is never sooner than H+1. This applies to the same bank and to a different bank.
- R7: A read strobe that follows a write falls exactly H+3 clocks after the write strobe rose, and the data enable is low in the two clocks before the read strobe falls.
- R8: Acknowledge passes through a two-flop synchronizer. The strobe ends at the end of the first clock in which the wait count has run out and the synchronized acknowledge is high. If acknowledge rises in the middle of strobe clock c, the strobe lasts max(max(W,2), c+2) clocks.
- R9: If the synchronized acknowledge stays low, the strobe ends after max(W,2)+T clocks, where T is `cfg_tmo`. `err_tmo` is high for exactly the first clock after that strobe rises and low at all other times.
- R10: With `cfg_async` low, the strobe lasts exactly 2 clocks, the hold is 0 and acknowledge is ignored.
- R11: `req_ready` is high only while no access is in progress. A read request is held off for one extra idle clock after a write ends. Wait, hold, timeout and mode are captured when a request is accepted, so later changes do not affect that access.
- R12: A read drives only the read strobe, low for max(W,2) clocks (subject to R8 and R9). The write strobe stays high and the data enable stays low throughout the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this clock when valid is also high |
| req_read | input | 1 | 1 = read start, 0 = write |
| req_bank | input | BANK_W | Bank to select |
| req_addr | input | ADDR_W | Access address |
| req_data | input | DATA_W | Write data |
| cfg_async | input | 1 | Bank is in asynchronous timing mode |
| cfg_wait | input | WAIT_W | Wait-state count W |
| cfg_hold | input | HOLD_W | Hold-cycle count H |
| cfg_tmo | input | TMO_W | Extra clocks allowed while acknowledge is low |
| mem_cs_n | output | NBANK | Chip selects, active low |
| mem_addr | output | ADDR_W | External address |
| mem_wdata | output | DATA_W | External write data |
| mem_wdata_oe | output | 1 | Data bus driver enable |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_ack | input | 1 | Device acknowledge, asynchronous |
| err_tmo | output | 1 | One-clock pulse when a stalled strobe was cut off |

## Verification
The assertions assume that `req_bank` names an existing bank, and that `mem_ack` meets timing at the synchronizer input. They also assume the request fields are held steady from the clock the request is raised until it is accepted, because no other ordering is checked. The stimulus changes every input half a clock away from the active edge and keeps each request stable until `req_ready` is seen. It changes acknowledge only while no request is pending, or at a planned point inside a strobe. Configuration is altered during an access only to show that the captured values are used.

// File: rtl/amw_pkg.sv
// Shared definitions for the asynchronous write strobe sequencer.
// Assumes: nothing beyond standard SystemVerilog.
package amw_pkg;

    // Shortest strobe in clocks, so that data is driven before the strobe rises
    localparam int unsigned AMW_MIN_STROBE  = 2;
    // Fixed strobe length when a bank is not in asynchronous mode
    localparam int unsigned AMW_SYNC_STROBE = 2;
    // Extra idle clocks a read waits after a write has fully ended
    localparam int unsigned AMW_RD_TURN     = 1;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_STROBE = 2'd2,
        ST_HOLD   = 2'd3
    } amw_state_e;

endpackage

// File: rtl/amw_ack_sync.sv
// Multi-flop synchronizer for the device acknowledge input.
// Assumes: ack_in may change at any time; STAGES is at least 2.
module amw_ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_in,
    output logic ack_sync
);

    logic [STAGES-1:0] shreg;

    // Shift the raw acknowledge through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else begin
            shreg <= {shreg[STAGES-2:0], ack_in};
        end
    end

    assign ack_sync = shreg[STAGES-1];

endmodule

// File: rtl/amw_strobe_timer.sv
// Times one strobe: counts wait clocks, then counts extension clocks while
// acknowledge is low, up to a timeout limit.
// Assumes: weff >= 2; run is high for exactly the strobe clocks of one access.
module amw_strobe_timer #(
    parameter int WAIT_W = 4,
    parameter int TMO_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [WAIT_W-1:0] weff,
    input  logic              ack_ok,
    input  logic [TMO_W-1:0]  tmo,
    output logic              first,
    output logic              done,
    output logic              timed_out
);

    logic [WAIT_W-1:0] cnt;
    logic [WAIT_W:0]   cnt_nx;
    logic [TMO_W-1:0]  ext;
    logic              wait_done;
    logic              ext_full;

    assign cnt_nx    = {1'b0, cnt} + {{WAIT_W{1'b0}}, 1'b1};
    assign wait_done = (cnt_nx >= {1'b0, weff});
    assign ext_full  = (ext == tmo);

    // Count wait clocks, then extension clocks, and clear between strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            ext <= '0;
        end else if (!run) begin
            cnt <= '0;
            ext <= '0;
        end else if (!wait_done) begin
            cnt <= cnt + WAIT_W'(1);
        end else if (!ack_ok && !ext_full) begin
            ext <= ext + TMO_W'(1);
        end
    end

    assign first     = run && (cnt == '0);
    assign done      = run && wait_done && (ack_ok || ext_full);
    assign timed_out = run && wait_done && !ack_ok && ext_full;

endmodule

// File: rtl/amw_turn_gap.sv
// Holds off read requests for a fixed number of idle clocks after a write ends.
// Assumes: wr_end pulses for one clock as the sequencer returns to idle.
module amw_turn_gap #(
    parameter int TURN = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_end,
    input  logic idle,
    output logic rd_block
);

    localparam int GAP_W = (TURN > 1) ? $clog2(TURN + 1) : 1;

    logic [GAP_W-1:0] gap;

    // Load the turnaround count at write end and run it down while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap <= '0;
        end else if (wr_end) begin
            gap <= GAP_W'(TURN);
        end else if (idle && (gap != '0)) begin
            gap <= gap - GAP_W'(1);
        end
    end

    assign rd_block = (gap != '0);

endmodule

// File: rtl/amw_seq.sv
// Asynchronous memory access sequencer (top). Accepts one write or read-start
// request at a time and produces setup, strobe and hold phases with chip
// select, address, data enable and active-low strobes.
// Assumes: req_bank < NBANK; request fields are stable while req_valid is high
// and not yet accepted; mem_ack is asynchronous to clk.
module amw_seq
    import amw_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int NBANK  = 4,
    parameter int WAIT_W = 4,
    parameter int HOLD_W = 3,
    parameter int TMO_W  = 8,
    localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_read,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic              cfg_async,
    input  logic [WAIT_W-1:0] cfg_wait,
    input  logic [HOLD_W-1:0] cfg_hold,
    input  logic [TMO_W-1:0]  cfg_tmo,
    output logic [NBANK-1:0]  mem_cs_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_wdata_oe,
    output logic              mem_we_n,
    output logic              mem_rd_n,
    input  logic              mem_ack,
    output logic              err_tmo
);

    amw_state_e        state;
    logic              rd_q;
    logic [BANK_W-1:0] bank_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              async_q;
    logic [WAIT_W-1:0] weff_q;
    logic [HOLD_W-1:0] hold_q;
    logic [TMO_W-1:0]  tmo_q;
    logic [HOLD_W-1:0] hcnt;
    logic              err_q;

    logic [WAIT_W-1:0] weff_req;
    logic              ack_s;
    logic              ack_ok;
    logic              strobe_run;
    logic              strobe_first;
    logic              strobe_done;
    logic              strobe_tmo;
    logic              rd_block;
    logic              accept;
    logic              busy;
    logic              wr_end;

    // Effective wait count for an incoming request
    always_comb begin
        if (!cfg_async) begin
            weff_req = WAIT_W'(AMW_SYNC_STROBE);
        end else if (cfg_wait < WAIT_W'(AMW_MIN_STROBE)) begin
            weff_req = WAIT_W'(AMW_MIN_STROBE);
        end else begin
            weff_req = cfg_wait;
        end
    end

    assign busy       = (state != ST_IDLE);
    assign req_ready  = !busy && !(req_read && rd_block);
    assign accept     = req_valid && req_ready;
    assign strobe_run = (state == ST_STROBE);
    assign ack_ok     = !async_q || ack_s;
    assign wr_end     = !rd_q &&
                        ((strobe_done && (hold_q == '0)) ||
                         ((state == ST_HOLD) && (hcnt == HOLD_W'(1))));

    amw_ack_sync #(
        .STAGES (2)
    ) ack_sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ack_in   (mem_ack),
        .ack_sync (ack_s)
    );

    amw_strobe_timer #(
        .WAIT_W (WAIT_W),
        .TMO_W  (TMO_W)
    ) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (strobe_run),
        .weff      (weff_q),
        .ack_ok    (ack_ok),
        .tmo       (tmo_q),
        .first     (strobe_first),
        .done      (strobe_done),
        .timed_out (strobe_tmo)
    );

    amw_turn_gap #(
        .TURN (AMW_RD_TURN)
    ) turn_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_end   (wr_end),
        .idle     (!busy),
        .rd_block (rd_block)
    );

    // Capture the request and its timing settings on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q    <= 1'b0;
            bank_q  <= '0;
            addr_q  <= '0;
            data_q  <= '0;
            async_q <= 1'b0;
            weff_q  <= WAIT_W'(AMW_MIN_STROBE);
            hold_q  <= '0;
            tmo_q   <= '0;
        end else if (accept) begin
            rd_q    <= req_read;
            bank_q  <= req_bank;
            addr_q  <= req_addr;
            data_q  <= req_data;
            async_q <= cfg_async;
            weff_q  <= weff_req;
            hold_q  <= cfg_async ? cfg_hold : '0;
            tmo_q   <= cfg_tmo;
        end
    end

    // Phase sequencing: idle, setup, strobe, optional hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            hcnt  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    state <= ST_STROBE;
                end
                ST_STROBE: begin
                    if (strobe_done) begin
                        if (!rd_q && (hold_q != '0)) begin
                            state <= ST_HOLD;
                            hcnt  <= hold_q;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_HOLD: begin
                    if (hcnt == HOLD_W'(1)) begin
                        state <= ST_IDLE;
                    end else begin
                        hcnt <= hcnt - HOLD_W'(1);
                    end
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // Timeout flag: one clock, aligned with the strobe rising
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else begin
            err_q <= strobe_tmo;
        end
    end

    // One chip select per bank, low during setup, strobe and hold
    for (genvar b = 0; b < NBANK; b++) begin : g_cs
        assign mem_cs_n[b] = !(busy && (bank_q == BANK_W'(b)));
    end

    assign mem_addr     = addr_q;
    assign mem_wdata    = data_q;
    assign mem_we_n     = !(strobe_run && !rd_q);
    assign mem_rd_n     = !(strobe_run && rd_q);
    assign mem_wdata_oe = (strobe_run && !rd_q && !strobe_first) ||
                          (state == ST_HOLD);
    assign err_tmo      = err_q;

endmodule

// File: rtl/amw_seq_chk.sv
// Protocol checker for amw_seq, attached through bind.
// Assumes: it sees the top-level ports of amw_seq only.
module amw_seq_chk #(
    parameter int NBANK  = 4,
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic [NBANK-1:0]  mem_cs_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_wdata_oe,
    input logic              mem_we_n,
    input logic              mem_rd_n,
    input logic              err_tmo
);

    // R2
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_cs_n));

    // R2
    wr_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> (mem_cs_n == $past(mem_cs_n)) && !(&mem_cs_n)
                            && (mem_addr == $past(mem_addr)));

    // R2
    rd_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_rd_n) |-> (mem_cs_n == $past(mem_cs_n)) && !(&mem_cs_n));

    // R2
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&mem_cs_n) && !(&$past(mem_cs_n))) |-> $stable(mem_addr));

    // R4
    data_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> !mem_wdata_oe);

    // R4
    data_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |=> mem_wdata_oe);

    // R4
    oe_in_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wdata_oe |-> !(&mem_cs_n));

    // R7
    rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_rd_n) |-> !mem_wdata_oe && !$past(mem_wdata_oe)
                            && !$past(mem_wdata_oe, 2));

    // R9
    err_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_tmo |-> ($rose(mem_we_n) || $rose(mem_rd_n)));

    // R11
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (&mem_cs_n) && mem_we_n && mem_rd_n);

    // R12
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_n || mem_rd_n);

endmodule

bind amw_seq amw_seq_chk #(
    .NBANK  (NBANK),
    .ADDR_W (ADDR_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_ready    (req_ready),
    .mem_cs_n     (mem_cs_n),
    .mem_addr     (mem_addr),
    .mem_wdata_oe (mem_wdata_oe),
    .mem_we_n     (mem_we_n),
    .mem_rd_n     (mem_rd_n),
    .err_tmo      (err_tmo)
);

// File: tb/amw_seq_tb_top.sv
// Scoreboard bench for amw_seq: the driver queues expected accesses, the
// monitor matches them against the strobe waveforms it observes.
module amw_seq_tb_top;

    localparam int AW = 16;
    localparam int DW = 16;
    localparam int NB = 4;
    localparam int BW = 2;
    localparam int WW = 4;
    localparam int HW = 3;
    localparam int TW = 8;

    typedef struct {
        bit    rd;
        int    bank;
        int    addr;
        int    data;
        int    exp_low;
        int    exp_hold;
        bit    exp_err;
        bit    chk_gap;
        string tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_read = 1'b0;
    logic [BW-1:0] req_bank = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic          cfg_async = 1'b1;
    logic [WW-1:0] cfg_wait = '0;
    logic [HW-1:0] cfg_hold = '0;
    logic [TW-1:0] cfg_tmo = '0;
    logic [NB-1:0] mem_cs_n;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_wdata_oe;
    logic          mem_we_n;
    logic          mem_rd_n;
    logic          mem_ack = 1'b1;
    logic          err_tmo;

    int   total = 0;
    int   fails = 0;
    bit   finished = 1'b0;
    exp_t q[$];

    always #10 clk = ~clk;

    amw_seq dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_read     (req_read),
        .req_bank     (req_bank),
        .req_addr     (req_addr),
        .req_data     (req_data),
        .cfg_async    (cfg_async),
        .cfg_wait     (cfg_wait),
        .cfg_hold     (cfg_hold),
        .cfg_tmo      (cfg_tmo),
        .mem_cs_n     (mem_cs_n),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_wdata_oe (mem_wdata_oe),
        .mem_we_n     (mem_we_n),
        .mem_rd_n     (mem_rd_n),
        .mem_ack      (mem_ack),
        .err_tmo      (err_tmo)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int weff_f(input bit am, input int w);
        if (!am) return 2;
        return (w < 2) ? 2 : w;
    endfunction

    // Driver: present one request, queue its expectation, wait for acceptance
    task automatic send(input bit rd, input int bank, input int addr,
                        input int data, input int w, input int h, input bit am,
                        input int tmo, input int exp_low, input bit exp_err,
                        input bit gap, input string tag);
        exp_t it;
        @(negedge clk);
        req_valid = 1'b1;
        req_read  = rd;
        req_bank  = BW'(bank);
        req_addr  = AW'(addr);
        req_data  = DW'(data);
        cfg_async = am;
        cfg_wait  = WW'(w);
        cfg_hold  = HW'(h);
        cfg_tmo   = TW'(tmo);
        while (!req_ready) @(negedge clk);
        it.rd       = rd;
        it.bank     = bank;
        it.addr     = addr;
        it.data     = data;
        it.exp_low  = (exp_low < 0) ? weff_f(am, w) : exp_low;
        it.exp_hold = (rd || !am) ? 0 : h;
        it.exp_err  = exp_err;
        it.chk_gap  = gap;
        it.tag      = tag;
        q.push_back(it);
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    // Monitor state
    int   cyc = 0;
    bit   p_lo = 1'b0;
    bit   p_oe = 1'b0;
    bit   p2_oe = 1'b0;
    int   p_cs = 15;
    bit   active = 1'b0;
    bit   in_hold = 1'b0;
    bit   hold_bad = 1'b0;
    int   low_len = 0;
    int   hold_len = 0;
    int   t_rise = 0;
    int   prev_h = 0;
    bit   prev_wr = 1'b0;
    exp_t cur;

    // Monitor: pop an expectation at each strobe start and compare the phases
    always @(negedge clk) begin
        if (rst_n) begin
            bit lo;
            bit rise;
            cyc++;
            lo   = !mem_we_n || !mem_rd_n;
            rise = !lo && p_lo;
            if (lo && !p_lo) begin
                if (q.size() == 0) begin
                    chk("R11 strobe without request", 1, 0);
                end else begin
                    cur    = q.pop_front();
                    active = 1'b1;
                    chk("R12 strobe kind", int'(!mem_rd_n), int'(cur.rd));
                    chk("R2 address", int'(mem_addr), cur.addr);
                    chk("R2 bank select", int'(mem_cs_n), (~(1 << cur.bank)) & 15);
                    chk("R2 setup clock", p_cs, int'(mem_cs_n));
                    if (!cur.rd) chk("R4 data value", int'(mem_wdata), cur.data);
                    chk("R4 data enable in first strobe clock", int'(mem_wdata_oe), 0);
                    if (cur.chk_gap && prev_wr) begin
                        if (cur.rd) chk("R7 write-to-read gap", cyc - t_rise, prev_h + 3);
                        else        chk("R6 write-to-write gap", cyc - t_rise, prev_h + 2);
                    end
                    if (cur.rd) chk("R7 bus released before read", int'(p_oe | p2_oe), 0);
                    low_len = 1;
                end
            end else if (lo && active) begin
                low_len++;
                if (!cur.rd && low_len == 2) chk("R4 data enable on", int'(mem_wdata_oe), 1);
                if (cur.rd) chk("R12 no data enable in read", int'(mem_wdata_oe), 0);
            end
            if (rise && active) begin
                chk({cur.tag, " strobe length"}, low_len, cur.exp_low);
                chk("R9 error flag at strobe end", int'(err_tmo), int'(cur.exp_err));
                t_rise   = cyc;
                hold_len = 0;
                hold_bad = 1'b0;
                in_hold  = 1'b1;
            end else if (err_tmo) begin
                chk("R9 stray error flag", 1, 0);
            end
            if (in_hold) begin
                if (!(&mem_cs_n)) begin
                    hold_len++;
                    if (!mem_wdata_oe || int'(mem_addr) != cur.addr) hold_bad = 1'b1;
                end else begin
                    chk("R5 hold length", hold_len, cur.exp_hold);
                    chk("R4 data enable through hold", int'(hold_bad), 0);
                    chk("R4 data enable off after release", int'(mem_wdata_oe), 0);
                    prev_h  = cur.exp_hold;
                    prev_wr = !cur.rd;
                    in_hold = 1'b0;
                    active  = 1'b0;
                end
            end
            p2_oe = p_oe;
            p_oe  = mem_wdata_oe;
            p_cs  = int'(mem_cs_n);
            p_lo  = lo;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    // Stimulus sequence
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 chip selects idle", int'(mem_cs_n), 15);
        chk("R1 write strobe idle", int'(mem_we_n), 1);
        chk("R1 read strobe idle", int'(mem_rd_n), 1);
        chk("R1 data enable idle", int'(mem_wdata_oe), 0);
        chk("R1 ready", int'(req_ready), 1);
        chk("R1 error flag", int'(err_tmo), 0);

        // R3, R11: wait 0 -> 2 clocks; config change after acceptance is ignored
        send(0, 0, 'h1234, 'hA5A5, 0, 0, 1, 20, -1, 0, 0, "R3");
        @(negedge clk);
        chk("R11 not ready while busy", int'(req_ready), 0);
        cfg_wait = 4'd9;
        // R6 back-to-back writes, varied banks, wait and hold
        send(0, 1, 'h0042, 'h5A5A, 5, 2, 1, 20, -1, 0, 1, "R3");
        send(0, 2, 'h00FF, 'h1111, 1, 3, 1, 20, -1, 0, 1, "R3");
        // R7 read after write, R12 read strobe
        send(1, 2, 'h0100, 0, 3, 0, 1, 20, -1, 0, 1, "R12");
        send(0, 3, 'hBEEF, 'hC0DE, 4, 1, 1, 20, -1, 0, 0, "R3");
        // R6 same bank
        send(0, 3, 'hBEF0, 'h0F0F, 2, 0, 1, 20, -1, 0, 1, "R3");
        send(1, 0, 'h0007, 0, 2, 0, 1, 20, -1, 0, 1, "R12");
        repeat (10) @(negedge clk);

        // R10: non-asynchronous bank ignores wait, hold and a low acknowledge
        mem_ack = 1'b0;
        repeat (3) @(negedge clk);
        send(0, 1, 'h3333, 'h4444, 7, 3, 0, 0, -1, 0, 0, "R10");
        repeat (10) @(negedge clk);

        // R8: acknowledge raised in strobe clock 4 with wait 2 -> 6 clocks
        send(0, 2, 'h5555, 'h6666, 2, 1, 1, 50, 6, 0, 0, "R8");
        @(negedge clk);
        @(negedge clk);
        repeat (3) @(negedge clk);
        mem_ack = 1'b1;
        repeat (12) @(negedge clk);

        // R8: acknowledge raised in strobe clock 1 with wait 6 -> 6 clocks
        mem_ack = 1'b0;
        repeat (3) @(negedge clk);
        send(0, 0, 'h7777, 'h8888, 6, 0, 1, 50, 6, 0, 0, "R8");
        @(negedge clk);
        @(negedge clk);
        mem_ack = 1'b1;
        repeat (12) @(negedge clk);

        // R9: acknowledge stuck low, wait 3, timeout 4 -> 7 clocks and error
        mem_ack = 1'b0;
        repeat (3) @(negedge clk);
        send(0, 1, 'h0AAA, 'h0BBB, 3, 1, 1, 4, 7, 1, 0, "R9");
        repeat (15) @(negedge clk);
        mem_ack = 1'b1;
        repeat (5) @(negedge clk);

        chk("R11 every request completed", q.size(), 0);
        finished = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule